// File: doc/BRIEF.md
# Probabilistic Bit Array Control and Readout Map

This block is the host-facing register map for an array of probabilistic bit cells. A host reaches it over a 32-bit AXI4-Lite slave. The address space has three regions. The global region holds fixed information words, the run/pause control and a counter of elapsed synapse periods. The readout region returns a packed snapshot of every cell's current output. The per-cell window turns host writes into one-cycle write strobes toward single cells, or toward every cell's activation table at once.

While the network runs, the snapshot register copies the cell outputs on every clock. Once the host pauses the network, the snapshot freezes, and the host can read all words of one consistent picture. Readout words can still be read while the network runs, but those reads are flagged with an error response.

All five AXI4-Lite channels use valid/ready handshakes. Each of the AW and W channels holds a single entry, and that channel's ready stays low until the write commits. A new write is not committed while the previous B response is still waiting for `s_bready_i`. The AR channel is accepted only when no R beat is pending. An R or B beat, once raised, holds its payload until its ready is seen. The cell-side strobes and the tick and state inputs are plain signals with no back-pressure.

Top module: `prob_array_csr`

## Requirements
- R1: Global word reads are fixed at these byte offsets: 0x00 returns NUM_BITS, 0x04 returns TOPO_CODE, 0x08 returns WEIGHT_BITS. Any global offset other than 0x00 to 0x10 reads as zero. Writes to the read-only words change nothing.
- R2: Bit 0 of the control word at byte 0x10 drives `run_o`, and a write takes effect only when byte lane 0 is enabled. After reset the value is 0 (paused), and a read of 0x10 returns it in bit 0.
- R3: The readout region is selected by address bits [15:14]=01. Word w, at byte 0x4000+4w, holds cell i at bit i mod 32 of word i/32. The snapshot is refreshed on each clock edge at which `run_o` is high. While paused, readout reads return OKAY and the frozen snapshot, and words past the last cell read as zero.
- R4: A readout read accepted while `run_o` is high returns SLVERR (2'b10), and its data is the snapshot register as it stood at acceptance.
- R5: The elapsed counter (byte 0x0C) adds one for each cycle in which `synapse_tick_i` is high while running. Ticks while paused are ignored. A read of 0x0C returns the count and clears it.
- R6: The elapsed counter stops at 2^CNT_W-1 instead of wrapping.
- R7: When a clearing read is accepted in a cycle that also carries a counted tick, the read returns the old value and the counter restarts at 1.
- R8: The per-cell window is selected by address bit 15 = 1. Bits [14:8] give the cell index and bits [7:2] give the word offset. The decoded word offsets are: 0 control (field 0), 1 seed (field 1), 2 bias (field 2), 8..15 weight entries 0..7 (field 3), and 32..63 table entries 0..31 (field 4). A write to cell index k < NUM_BITS at one of these offsets raises `cell_wr_en_o[k]` alone for one cycle, with the field code, entry and data. That cycle is the first cycle of the B response.
- R9: Cell index 127 is reserved for broadcast. A write there at a table offset raises every bit of `cell_wr_en_o` in the same cycle, with field 4.
- R10: Some per-cell writes raise no strobe at all: an undefined offset, an index of NUM_BITS or more (other than 127), or index 127 with a non-table offset. Every read in the per-cell window returns zero with OKAY.
- R11: AW and W may arrive in either order or together. Each write gets exactly one B beat with OKAY, and that beat holds until `s_bready_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| s_awvalid_i | input | 1 | Write address valid |
| s_awready_o | output | 1 | Write address ready |
| s_awaddr_i | input | 16 | Write byte address |
| s_wvalid_i | input | 1 | Write data valid |
| s_wready_o | output | 1 | Write data ready |
| s_wdata_i | input | 32 | Write data |
| s_wstrb_i | input | 4 | Write byte enables |
| s_bvalid_o | output | 1 | Write response valid |
| s_bready_i | input | 1 | Write response ready |
| s_bresp_o | output | 2 | Write response code |
| s_arvalid_i | input | 1 | Read address valid |
| s_arready_o | output | 1 | Read address ready |
| s_araddr_i | input | 16 | Read byte address |
| s_rvalid_o | output | 1 | Read data valid |
| s_rready_i | input | 1 | Read data ready |
| s_rdata_o | output | 32 | Read data |
| s_rresp_o | output | 2 | Read response code |
| bit_state_i | input | NUM_BITS | Live output of every cell |
| synapse_tick_i | input | 1 | One pulse per synapse period |
| run_o | output | 1 | Network enable (1 = running) |
| cell_wr_en_o | output | NUM_BITS | Per-cell write strobe |
| cell_wr_field_o | output | 3 | Field code of the strobed write |
| cell_wr_entry_o | output | 5 | Weight or table entry index |
| cell_wr_data_o | output | 32 | Data for the strobed write |

## Verification
Two functions can land in the same cycle: clearing the elapsed counter with a read, and counting a synapse tick. The bench provokes this by raising `synapse_tick_i` for exactly the cycle in which its read address is accepted. It expects the old count in that read and a count of 1 in the read that follows. A second collision is a pause write that commits while the snapshot is still sampling. The bench changes the cell pattern right after the pause and expects the readout to show the pattern from before the pause.

// File: rtl/prob_csr_pkg.sv
package prob_csr_pkg;

  localparam int CSR_AW  = 16;
  localparam int IDX_W   = 7;
  localparam int ENTRY_W = 5;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  localparam logic [11:0] GW_COUNT   = 12'd0;
  localparam logic [11:0] GW_TOPO    = 12'd1;
  localparam logic [11:0] GW_PREC    = 12'd2;
  localparam logic [11:0] GW_ELAPSED = 12'd3;
  localparam logic [11:0] GW_CTRL    = 12'd4;

  typedef enum logic [2:0] {
    FLD_CTRL   = 3'd0,
    FLD_SEED   = 3'd1,
    FLD_BIAS   = 3'd2,
    FLD_WEIGHT = 3'd3,
    FLD_TABLE  = 3'd4,
    FLD_NONE   = 3'd7
  } cell_field_e;

  typedef enum logic [1:0] {
    RGN_GLOBAL  = 2'd0,
    RGN_READOUT = 2'd1,
    RGN_CELL    = 2'd2
  } region_e;

  typedef struct packed {
    cell_field_e          fld;
    logic [ENTRY_W-1:0]   entry;
  } cell_sel_t;

  function automatic region_e region_of(input logic [1:0] top_bits);
    if (top_bits[1])      return RGN_CELL;
    else if (top_bits[0]) return RGN_READOUT;
    else                  return RGN_GLOBAL;
  endfunction

  function automatic cell_sel_t cell_offset_decode(input logic [5:0] w);
    cell_sel_t s;
    s.fld   = FLD_NONE;
    s.entry = '0;
    if (w == 6'd0)      s.fld = FLD_CTRL;
    else if (w == 6'd1) s.fld = FLD_SEED;
    else if (w == 6'd2) s.fld = FLD_BIAS;
    else if (w[5:3] == 3'b001) begin
      s.fld   = FLD_WEIGHT;
      s.entry = {2'b00, w[2:0]};
    end else if (w[5]) begin
      s.fld   = FLD_TABLE;
      s.entry = w[4:0];
    end
    return s;
  endfunction

endpackage

// File: rtl/csr_axil_wr.sv
module csr_axil_wr
  import prob_csr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                awvalid_i,
  output logic                awready_o,
  input  logic [CSR_AW-1:0]   awaddr_i,
  input  logic                wvalid_i,
  output logic                wready_o,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [DATA_W/8-1:0] wstrb_i,
  output logic                bvalid_o,
  input  logic                bready_i,
  output logic [1:0]          bresp_o,
  output logic                commit_o,
  output logic [CSR_AW-1:0]   commit_addr_o,
  output logic [DATA_W-1:0]   commit_data_o,
  output logic [DATA_W/8-1:0] commit_strb_o
);

  logic aw_full_q, w_full_q, bvalid_q;

  assign awready_o = !aw_full_q;
  assign wready_o  = !w_full_q;
  assign commit_o  = aw_full_q && w_full_q && !bvalid_q;
  assign bvalid_o  = bvalid_q;
  assign bresp_o   = RESP_OKAY;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      aw_full_q     <= 1'b0;
      w_full_q      <= 1'b0;
      bvalid_q      <= 1'b0;
      commit_addr_o <= '0;
      commit_data_o <= '0;
      commit_strb_o <= '0;
    end else begin
      if (awvalid_i && !aw_full_q) begin
        aw_full_q     <= 1'b1;
        commit_addr_o <= awaddr_i;
      end
      if (wvalid_i && !w_full_q) begin
        w_full_q      <= 1'b1;
        commit_data_o <= wdata_i;
        commit_strb_o <= wstrb_i;
      end
      if (commit_o) begin
        aw_full_q <= 1'b0;
        w_full_q  <= 1'b0;
        bvalid_q  <= 1'b1;
      end else if (bvalid_q && bready_i) begin
        bvalid_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/csr_cell_decode.sv
module csr_cell_decode
  import prob_csr_pkg::*;
#(
  parameter int NUM_BITS = 64,
  parameter int DATA_W   = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               commit_i,
  input  logic [CSR_AW-1:0]  addr_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [NUM_BITS-1:0] wr_en_o,
  output logic [2:0]         field_o,
  output logic [ENTRY_W-1:0] entry_o,
  output logic [DATA_W-1:0]  data_o
);

  localparam logic [IDX_W-1:0] BCAST_IDX = '1;

  cell_sel_t         sel;
  logic [IDX_W-1:0]  idx;
  logic              in_window;
  logic              bcast_ok;
  logic [NUM_BITS-1:0] hit;

  assign sel       = cell_offset_decode(addr_i[7:2]);
  assign idx       = addr_i[14:8];
  assign in_window = commit_i && (region_of(addr_i[15:14]) == RGN_CELL)
                     && (sel.fld != FLD_NONE);
  assign bcast_ok  = (idx == BCAST_IDX) && (sel.fld == FLD_TABLE);

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_hit
    assign hit[i] = in_window && (bcast_ok || (idx == IDX_W'(i)));
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      wr_en_o <= '0;
      field_o <= FLD_NONE;
      entry_o <= '0;
      data_o  <= '0;
    end else begin
      wr_en_o <= hit;
      if (|hit) begin
        field_o <= sel.fld;
        entry_o <= sel.entry;
        data_o  <= data_i;
      end
    end
  end

endmodule

// File: rtl/csr_elapsed_ctr.sv
module csr_elapsed_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic counted;
  assign counted = tick_i && run_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                           count_o <= '0;
    else if (clr_i)                        count_o <= counted ? CNT_W'(1) : '0;
    else if (counted && count_o != CNT_MAX) count_o <= count_o + 1'b1;
  end

endmodule

// File: rtl/prob_array_csr.sv
module prob_array_csr
  import prob_csr_pkg::*;
#(
  parameter int          NUM_BITS    = 64,
  parameter int          CNT_W       = 16,
  parameter int          WEIGHT_BITS = 8,
  parameter logic [31:0] TOPO_CODE   = 32'd2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                s_awvalid_i,
  output logic                s_awready_o,
  input  logic [15:0]         s_awaddr_i,
  input  logic                s_wvalid_i,
  output logic                s_wready_o,
  input  logic [31:0]         s_wdata_i,
  input  logic [3:0]          s_wstrb_i,
  output logic                s_bvalid_o,
  input  logic                s_bready_i,
  output logic [1:0]          s_bresp_o,
  input  logic                s_arvalid_i,
  output logic                s_arready_o,
  input  logic [15:0]         s_araddr_i,
  output logic                s_rvalid_o,
  input  logic                s_rready_i,
  output logic [31:0]         s_rdata_o,
  output logic [1:0]          s_rresp_o,
  input  logic [NUM_BITS-1:0] bit_state_i,
  input  logic                synapse_tick_i,
  output logic                run_o,
  output logic [NUM_BITS-1:0] cell_wr_en_o,
  output logic [2:0]          cell_wr_field_o,
  output logic [4:0]          cell_wr_entry_o,
  output logic [31:0]         cell_wr_data_o
);

  localparam int NUM_WORDS = (NUM_BITS + 31) / 32;
  localparam int SNAP_W    = NUM_WORDS * 32;

  logic              commit;
  logic [15:0]       c_addr;
  logic [31:0]       c_data;
  logic [3:0]        c_strb;
  logic              run_q;
  logic [SNAP_W-1:0] snap_q;
  logic [CNT_W-1:0]  elapsed_q;
  logic              ar_fire, rd_clr, rvalid_q;
  logic [31:0]       rd_data;
  logic [1:0]        rd_resp;
  region_e           rd_rgn;

  csr_axil_wr #(.DATA_W(32)) u_wr (
    .clk_i, .rst_ni,
    .awvalid_i(s_awvalid_i), .awready_o(s_awready_o), .awaddr_i(s_awaddr_i),
    .wvalid_i(s_wvalid_i), .wready_o(s_wready_o), .wdata_i(s_wdata_i),
    .wstrb_i(s_wstrb_i), .bvalid_o(s_bvalid_o), .bready_i(s_bready_i),
    .bresp_o(s_bresp_o), .commit_o(commit), .commit_addr_o(c_addr),
    .commit_data_o(c_data), .commit_strb_o(c_strb)
  );

  csr_cell_decode #(.NUM_BITS(NUM_BITS), .DATA_W(32)) u_cell (
    .clk_i, .rst_ni, .commit_i(commit), .addr_i(c_addr), .data_i(c_data),
    .wr_en_o(cell_wr_en_o), .field_o(cell_wr_field_o),
    .entry_o(cell_wr_entry_o), .data_o(cell_wr_data_o)
  );

  csr_elapsed_ctr #(.CNT_W(CNT_W)) u_elapsed (
    .clk_i, .rst_ni, .tick_i(synapse_tick_i), .run_i(run_q),
    .clr_i(rd_clr), .count_o(elapsed_q)
  );

  // Run/pause control word.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) run_q <= 1'b0;
    else if (commit && region_of(c_addr[15:14]) == RGN_GLOBAL &&
             c_addr[13:2] == GW_CTRL && c_strb[0])
      run_q <= c_data[0];
  end
  assign run_o = run_q;

  // Snapshot follows the cells only while running.
  always_ff @(posedge clk_i) begin
    if (!rst_ni)    snap_q <= '0;
    else if (run_q) snap_q <= SNAP_W'(bit_state_i);
  end

  // Read path.
  assign rd_rgn      = region_of(s_araddr_i[15:14]);
  assign s_arready_o = !rvalid_q;
  assign ar_fire     = s_arvalid_i && !rvalid_q;
  assign rd_clr      = ar_fire && rd_rgn == RGN_GLOBAL && s_araddr_i[13:2] == GW_ELAPSED;

  always_comb begin
    rd_data = '0;
    rd_resp = RESP_OKAY;
    case (rd_rgn)
      RGN_GLOBAL: begin
        case (s_araddr_i[13:2])
          GW_COUNT:   rd_data = 32'(NUM_BITS);
          GW_TOPO:    rd_data = TOPO_CODE;
          GW_PREC:    rd_data = 32'(WEIGHT_BITS);
          GW_ELAPSED: rd_data = 32'(elapsed_q);
          GW_CTRL:    rd_data = {31'b0, run_q};
          default:    rd_data = '0;
        endcase
      end
      RGN_READOUT: begin
        for (int w = 0; w < NUM_WORDS; w++)
          if (s_araddr_i[13:2] == 12'(w)) rd_data = snap_q[w*32 +: 32];
        if (run_q) rd_resp = RESP_SLVERR;
      end
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rvalid_q  <= 1'b0;
      s_rdata_o <= '0;
      s_rresp_o <= RESP_OKAY;
    end else if (ar_fire) begin
      rvalid_q  <= 1'b1;
      s_rdata_o <= rd_data;
      s_rresp_o <= rd_resp;
    end else if (rvalid_q && s_rready_i) begin
      rvalid_q <= 1'b0;
    end
  end
  assign s_rvalid_o = rvalid_q;

endmodule

// File: rtl/prob_array_csr_chk.sv
module prob_array_csr_chk #(
  parameter int NUM_BITS = 64,
  parameter int CNT_W    = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 bvalid,
  input logic                 bready,
  input logic [1:0]           bresp,
  input logic                 rvalid,
  input logic                 rready,
  input logic [31:0]          rdata,
  input logic                 run,
  input logic                 tick,
  input logic [NUM_BITS-1:0]  wr_en,
  input logic [2:0]           wr_field,
  input logic [((NUM_BITS+31)/32)*32-1:0] snap,
  input logic [CNT_W-1:0]     cnt,
  input logic                 clr
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_bresp_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bvalid && !bready |=> bvalid && $stable(bresp));

  assert_rdata_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid && !rready |=> rvalid && $stable(rdata));

  assert_strobe_with_resp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_en) |-> $rose(bvalid));

  assert_bcast_table_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(wr_en) > 1) |-> wr_field == 3'd4);

  assert_paused_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> $stable(snap));

  assert_saturate_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == CNT_MAX) && !clr |=> cnt == CNT_MAX);

  assert_clear_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr && !(tick && run) |=> cnt == '0);

  assert_paused_no_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run && !clr |=> $stable(cnt));

endmodule

bind prob_array_csr prob_array_csr_chk #(.NUM_BITS(NUM_BITS), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .bvalid(s_bvalid_o), .bready(s_bready_i), .bresp(s_bresp_o),
  .rvalid(s_rvalid_o), .rready(s_rready_i), .rdata(s_rdata_o),
  .run(run_o), .tick(synapse_tick_i),
  .wr_en(cell_wr_en_o), .wr_field(cell_wr_field_o),
  .snap(snap_q), .cnt(elapsed_q), .clr(rd_clr)
);

// File: tb/prob_array_csr_test.sv
module prob_array_csr_test;

  localparam int NB = 64;
  localparam int CW = 8;
  localparam logic [63:0] PAT_A = 64'hA5A5_0F0F_1234_8001;
  localparam logic [63:0] PAT_B = 64'h0000_FFFF_5555_AAAA;
  localparam logic [63:0] PAT_C = 64'h1111_2222_3333_4444;

  typedef struct packed {
    logic [15:0] addr;
    logic [31:0] exp;
  } rd_vec_t;

  localparam rd_vec_t RD_TBL [9] = '{
    '{16'h0000, 32'd64},
    '{16'h0004, 32'd2},
    '{16'h0008, 32'd8},
    '{16'h0018, 32'd0},
    '{16'h0010, 32'd0},
    '{16'h4000, 32'h1234_8001},
    '{16'h4004, 32'hA5A5_0F0F},
    '{16'h4008, 32'd0},
    '{16'h8504, 32'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [15:0] awaddr = '0, araddr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = 4'hF;
  logic awready, wready, bvalid, arready, rvalid, run;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata, cdata;
  logic [NB-1:0] bits = '0, cen;
  logic [2:0]  cfield;
  logic [4:0]  centry;
  logic tick = 1'b0;

  int checks = 0, errors = 0;
  logic [NB-1:0] got_en;
  logic [2:0]    got_field;
  logic [4:0]    got_entry;
  logic [31:0]   got_data, rd_d;
  logic [1:0]    rd_r;

  always #5 clk = ~clk;

  prob_array_csr #(.NUM_BITS(NB), .CNT_W(CW), .WEIGHT_BITS(8), .TOPO_CODE(32'd2)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .s_awvalid_i(awvalid), .s_awready_o(awready), .s_awaddr_i(awaddr),
    .s_wvalid_i(wvalid), .s_wready_o(wready), .s_wdata_i(wdata), .s_wstrb_i(wstrb),
    .s_bvalid_o(bvalid), .s_bready_i(bready), .s_bresp_o(bresp),
    .s_arvalid_i(arvalid), .s_arready_o(arready), .s_araddr_i(araddr),
    .s_rvalid_o(rvalid), .s_rready_i(rready), .s_rdata_o(rdata), .s_rresp_o(rresp),
    .bit_state_i(bits), .synapse_tick_i(tick), .run_o(run),
    .cell_wr_en_o(cen), .cell_wr_field_o(cfield), .cell_wr_entry_o(centry),
    .cell_wr_data_o(cdata)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send_aw(input logic [15:0] a);
    awaddr = a; awvalid = 1'b1;
    while (!awready) @(negedge clk);
    @(negedge clk); awvalid = 1'b0;
  endtask

  task automatic send_w(input logic [31:0] d);
    wdata = d; wvalid = 1'b1;
    while (!wready) @(negedge clk);
    @(negedge clk); wvalid = 1'b0;
  endtask

  // order: 0 together, 1 address first, 2 data first
  task automatic axi_write(input logic [15:0] a, input logic [31:0] d, input int order);
    if (order == 0) begin
      awaddr = a; wdata = d; awvalid = 1'b1; wvalid = 1'b1;
      while (!(awready && wready)) @(negedge clk);
      @(negedge clk); awvalid = 1'b0; wvalid = 1'b0;
    end else if (order == 1) begin
      send_aw(a); send_w(d);
    end else begin
      send_w(d); send_aw(a);
    end
    while (!bvalid) @(negedge clk);
    got_en = cen; got_field = cfield; got_entry = centry; got_data = cdata;
    check("R11 bresp okay", 64'(bresp), 64'd0);
    bready = 1'b1;
    @(negedge clk); bready = 1'b0;
    check("R11 single response", 64'(bvalid), 64'd0);
    @(negedge clk);
    check("R11 no extra response", 64'(bvalid), 64'd0);
  endtask

  task automatic axi_read(input logic [15:0] a, input logic with_tick);
    araddr = a; arvalid = 1'b1;
    while (!arready) @(negedge clk);
    tick = with_tick;
    @(negedge clk); arvalid = 1'b0; tick = 1'b0;
    while (!rvalid) @(negedge clk);
    rd_d = rdata; rd_r = rresp;
    rready = 1'b1;
    @(negedge clk); rready = 1'b0;
  endtask

  task automatic pulse_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog act=hung exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 reset paused", 64'(run), 64'd0);
    check("R11 reset no bvalid", 64'(bvalid), 64'd0);
    check("R11 reset ready", 64'({awready, wready, arready}), 64'h7);
    check("R8 reset no strobe", 64'(cen), 64'd0);

    // Run, readout while running (R4)
    bits = PAT_A;
    axi_write(16'h0010, 32'd1, 1);
    check("R2 run set", 64'(run), 64'd1);
    axi_read(16'h4000, 1'b0);
    check("R4 running resp", 64'(rd_r), 64'd2);
    check("R4 running data", 64'(rd_d), 64'(PAT_A[31:0]));

    // Pause, then change the cells: snapshot must hold PAT_A (R3)
    axi_write(16'h0010, 32'd0, 2);
    bits = PAT_B;
    check("R2 paused", 64'(run), 64'd0);

    // Vector table walk (R1, R3, R10)
    for (int v = 0; v < 9; v++) begin
      axi_read(RD_TBL[v].addr, 1'b0);
      check($sformatf("R1/R3/R10 vec %0d data", v), 64'(rd_d), 64'(RD_TBL[v].exp));
      check($sformatf("R1/R3/R10 vec %0d resp", v), 64'(rd_r), 64'd0);
    end

    // Read-only words ignore writes (R1)
    axi_write(16'h0000, 32'hFFFF_FFFF, 0);
    axi_read(16'h0000, 1'b0);
    check("R1 count unchanged", 64'(rd_d), 64'd64);

    // Control write with lane 0 disabled is dropped (R2)
    wstrb = 4'hE;
    axi_write(16'h0010, 32'd1, 0);
    wstrb = 4'hF;
    check("R2 masked lane", 64'(run), 64'd0);

    // Elapsed counter (R5)
    axi_read(16'h000C, 1'b0);
    check("R5 initial count", 64'(rd_d), 64'd0);
    axi_write(16'h0010, 32'd1, 0);
    pulse_ticks(5);
    axi_write(16'h0010, 32'd0, 0);
    axi_read(16'h000C, 1'b0);
    check("R5 five ticks", 64'(rd_d), 64'd5);
    pulse_ticks(3);
    axi_read(16'h000C, 1'b0);
    check("R5 paused ticks ignored", 64'(rd_d), 64'd0);

    // Saturation (R6)
    axi_write(16'h0010, 32'd1, 0);
    tick = 1'b1;
    repeat (300) @(negedge clk);
    tick = 1'b0;
    axi_write(16'h0010, 32'd0, 0);
    axi_read(16'h000C, 1'b0);
    check("R6 saturated", 64'(rd_d), 64'd255);

    // Clear coincident with a tick (R7)
    axi_write(16'h0010, 32'd1, 0);
    pulse_ticks(4);
    axi_read(16'h000C, 1'b1);
    check("R7 old value returned", 64'(rd_d), 64'd4);
    axi_read(16'h000C, 1'b0);
    check("R7 tick kept", 64'(rd_d), 64'd1);

    // Snapshot refreshes again while running (R3)
    bits = PAT_C;
    axi_write(16'h0010, 32'd0, 1);
    axi_read(16'h4004, 1'b0);
    check("R3 new snapshot", 64'(rd_d), 64'(PAT_C[63:32]));

    // Per-cell writes (R8, R9, R10)
    axi_write(16'h8528, 32'hCAFE_0005, 0);
    check("R8 cell5 strobe", 64'(got_en), 64'd1 << 5);
    check("R8 weight field", 64'({got_field, got_entry}), 64'({3'd3, 5'd2}));
    check("R8 data", 64'(got_data), 64'hCAFE_0005);
    axi_write(16'hBFA0, 32'h0000_0063, 2);
    check("R8 cell63 strobe", 64'(got_en), 64'd1 << 63);
    check("R8 table field", 64'({got_field, got_entry}), 64'({3'd4, 5'd8}));
    axi_write(16'h8004, 32'h0000_BEEF, 1);
    check("R8 seed cell0", 64'({got_en[0], got_field}), 64'({1'b1, 3'd1}));
    axi_write(16'hFF84, 32'h0000_0777, 1);
    check("R9 broadcast strobe", 64'(got_en), {64{1'b1}});
    check("R9 broadcast field", 64'({got_field, got_entry}), 64'({3'd4, 5'd1}));
    axi_write(16'hFF04, 32'h1, 0);
    check("R10 broadcast seed dropped", 64'(got_en), 64'd0);
    axi_write(16'hC600, 32'h1, 2);
    check("R10 index out of range", 64'(got_en), 64'd0);
    axi_write(16'h8350, 32'h1, 0);
    check("R10 undefined offset", 64'(got_en), 64'd0);
    check("R10 no strobe after", 64'(cen), 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule